// File: doc/BRIEF.md
# Compressed Register-Pair Load/Store Unit

This unit executes, on a 32-bit core, the 16-bit compressed instructions that move one 64-bit doubleword between memory and an even/odd pair of general registers. It decodes the register-based and stack-pointer-based load and store pair forms and rejects odd pair numbers, the reserved stack-pointer load with destination x0, and any other code point. For a legal instruction it forms the effective address and moves the doubleword as two 32-bit beats on a valid/ready memory port.

The core offers an instruction when the unit is not busy. The unit reads the base register through one combinational register-file read port and the store data through a second one. A load writes both registers of the pair in one cycle, through two write ports, and only after both beats have completed. A memory error response abandons the instruction and raises a one-cycle fault pulse. In that case no register is written.

Top module: `pair_ldst_unit`

## Requirements
- R1: Decoding uses funct3 at insn[15:13] and the quadrant at insn[1:0]. 011/00 is the register load, 111/00 the register store, 011/10 the stack-pointer load, and 111/10 the stack-pointer store. Every other encoding raises `illegal` for one cycle and makes no memory access.
- R2: The effective address A is the base register plus a zero-extended offset whose three low bits are zero. In the register forms the base is x8+insn[9:7] and the offset is {insn[6:5], insn[12:10], 000}. The stack-pointer forms use x2 as the base. The stack-pointer load offset is {insn[4:2], insn[12], insn[6:5], 000}. The stack-pointer store offset is {insn[9:7], insn[12:10], 000}.
- R3: A legal instruction makes exactly two memory beats, at A and then at A+4. While `mem_ready` is low, the request, address and write enable stay stable.
- R4: For a load, the word from the first beat (the low half) goes to the pair register p, and the word from the second beat goes to p+1. Both writes occur in the single cycle in which `done` is high.
- R5: For a store, register p is written to address A and register p+1 to address A+4.
- R6: The pair register p is x8+insn[4:2] in the register forms, insn[11:7] in the stack-pointer load and insn[6:2] in the stack-pointer store. An odd p is illegal.
- R7: A stack-pointer load with insn[11:7]=0 is a reserved code point and raises `illegal`.
- R8: A stack-pointer store with source x0 writes zero to both words.
- R9: A memory error response on either beat ends the instruction and raises `fault` for one cycle. It causes no register write and no further beat.
- R10: `busy` is high from the acceptance of an instruction until its `done` cycle. An instruction is taken only while `busy` is low. `done`, `illegal` and `fault` are single-cycle pulses and are never high together.
- R11: During and after reset the unit is idle, with no request, no pulse and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction offered |
| insn | input | 16 | Compressed instruction |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Instruction completed |
| illegal | output | 1 | Rejected encoding pulse |
| fault | output | 1 | Memory error abort pulse |
| rf_raddr_a | output | 5 | Base register read address |
| rf_rdata_a | input | 32 | Base register read data |
| rf_raddr_b | output | 5 | Store data read address |
| rf_rdata_b | input | 32 | Store data read data |
| rf_we0 | output | 1 | Low register write enable |
| rf_waddr0 | output | 5 | Low register write address |
| rf_wdata0 | output | 32 | Low register write data |
| rf_we1 | output | 1 | High register write enable |
| rf_waddr1 | output | 5 | High register write address |
| rf_wdata1 | output | 32 | High register write data |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Memory beat address |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory beat accepted |
| mem_rdata | input | 32 | Memory read data |
| mem_err | input | 1 | Memory error response |

## Verification
The assertions check on every cycle the handshake-level behaviour:
- the request holds steady under back-pressure;
- a completed first beat is followed by a beat at the address plus four;
- register writes land only in the completion cycle, on an even/odd pair;
- an error leads to the fault pulse with no write;
- an offered instruction is either taken or rejected;
- the three result pulses stay exclusive.

Only the bench scenarios show the rest:
- the decoded offset and base of each form;
- that the low and high words go to the right registers and addresses;
- the zero data of an x0 store;
- the reserved and odd-register encodings;
- that a load faulting on its second beat leaves the pair unchanged.

// File: rtl/pair_ldst_unit.sv
module pair_ldst_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        insn_valid,
  input  logic [15:0] insn,
  output logic        busy,
  output logic        done,
  output logic        illegal,
  output logic        fault,
  output logic [4:0]  rf_raddr_a,
  input  logic [31:0] rf_rdata_a,
  output logic [4:0]  rf_raddr_b,
  input  logic [31:0] rf_rdata_b,
  output logic        rf_we0,
  output logic [4:0]  rf_waddr0,
  output logic [31:0] rf_wdata0,
  output logic        rf_we1,
  output logic [4:0]  rf_waddr1,
  output logic [31:0] rf_wdata1,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err
);
  typedef enum logic [1:0] {S_IDLE, S_BEAT0, S_BEAT1, S_DONE} state_t;

  state_t      state;
  logic [4:0]  pr_q;
  logic        ld_q, ill_q, flt_q;
  logic [31:0] addr_q, lo_q, hi_q;

  wire is_ld   = insn[1:0] == 2'b00 && insn[15:13] == 3'b011;
  wire is_sd   = insn[1:0] == 2'b00 && insn[15:13] == 3'b111;
  wire is_ldsp = insn[1:0] == 2'b10 && insn[15:13] == 3'b011;
  wire is_sdsp = insn[1:0] == 2'b10 && insn[15:13] == 3'b111;

  logic [4:0] pr;
  logic [8:0] off;
  logic       ok;

  always_comb begin
    pr  = {2'b01, insn[4:2]};
    off = {1'b0, insn[6:5], insn[12:10], 3'b000};
    ok  = 1'b0;
    if (is_ld || is_sd) begin
      ok = ~insn[2];
    end else if (is_ldsp) begin
      pr  = insn[11:7];
      off = {insn[4:2], insn[12], insn[6:5], 3'b000};
      ok  = ~insn[7] && (insn[11:7] != 5'd0);
    end else if (is_sdsp) begin
      pr  = insn[6:2];
      off = {insn[9:7], insn[12:10], 3'b000};
      ok  = ~insn[2];
    end
  end

  wire accept = insn_valid && state == S_IDLE;
  wire beat   = mem_req && mem_ready;

  assign rf_raddr_a = (is_ldsp || is_sdsp) ? 5'd2 : {2'b01, insn[9:7]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pr_q   <= '0;
      ld_q   <= 1'b0;
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      ill_q  <= 1'b0;
      flt_q  <= 1'b0;
    end else begin
      ill_q <= accept && !ok;
      flt_q <= 1'b0;
      case (state)
        S_IDLE: if (accept && ok) begin
          state  <= S_BEAT0;
          pr_q   <= pr;
          ld_q   <= is_ld || is_ldsp;
          addr_q <= rf_rdata_a + {23'd0, off};
        end
        S_BEAT0: if (beat) begin
          if (mem_err) begin
            state <= S_IDLE;
            flt_q <= 1'b1;
          end else begin
            state <= S_BEAT1;
            lo_q  <= mem_rdata;
          end
        end
        S_BEAT1: if (beat) begin
          if (mem_err) begin
            state <= S_IDLE;
            flt_q <= 1'b1;
          end else begin
            state <= S_DONE;
            hi_q  <= mem_rdata;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = state != S_IDLE;
  assign done    = state == S_DONE;
  assign illegal = ill_q;
  assign fault   = flt_q;

  assign mem_req    = state == S_BEAT0 || state == S_BEAT1;
  assign mem_we     = mem_req && !ld_q;
  assign mem_addr   = (state == S_BEAT1) ? addr_q + 32'd4 : addr_q;
  assign rf_raddr_b = (state == S_BEAT1) ? (pr_q | 5'd1) : pr_q;
  assign mem_wdata  = (pr_q == 5'd0) ? 32'd0 : rf_rdata_b;

  assign rf_we0    = done && ld_q && pr_q != 5'd0;
  assign rf_waddr0 = pr_q;
  assign rf_wdata0 = lo_q;
  assign rf_we1    = done && ld_q;
  assign rf_waddr1 = pr_q | 5'd1;
  assign rf_wdata1 = hi_q;
endmodule

// File: rtl/pair_ldst_unit_chk.sv
module pair_ldst_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        insn_valid,
  input logic        busy,
  input logic        done,
  input logic        illegal,
  input logic        fault,
  input logic        rf_we0,
  input logic [4:0]  rf_waddr0,
  input logic        rf_we1,
  input logic [4:0]  rf_waddr1,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ready,
  input logic        mem_err
);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_next_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !mem_err) |=> (!mem_req || mem_addr == $past(mem_addr) + 32'd4));

  assert_write_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we0 || rf_we1) |-> (done && !mem_req));

  assert_pair_even_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we1 |-> (rf_waddr1[0] && rf_waddr1 == rf_waddr0 + 5'd1));

  assert_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && mem_err) |=> (fault && !busy && !rf_we0 && !rf_we1));

  assert_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_valid && !busy) |=> (busy || illegal));

  assert_req_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_pulses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, illegal, fault}));
endmodule

bind pair_ldst_unit pair_ldst_unit_chk u_chk (.*);

// File: tb/pair_ldst_unit_bench.sv
module pair_ldst_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        insn_valid = 1'b0;
  logic [15:0] insn = '0;
  logic        busy, done, illegal, fault;
  logic [4:0]  rf_raddr_a, rf_raddr_b, rf_waddr0, rf_waddr1;
  logic [31:0] rf_rdata_a, rf_rdata_b, rf_wdata0, rf_wdata1;
  logic        rf_we0, rf_we1;
  logic        mem_req, mem_we, mem_ready, mem_err;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  pair_ldst_unit u_pair_ldst_unit (.*);

  logic [31:0] rf [32];
  logic [31:0] mem [256];
  logic [31:0] beat_log [8];
  int          nbeat = 0;
  int          wcnt = 0;
  int          wait_cycles = 0;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = '0;
  int          n_chk = 0;
  int          n_err = 0;

  function automatic logic [31:0] rf_pat(int i);
    if (i == 0) return 32'd0;
    if (i == 2) return 32'h0000_0200;
    return {8'(i), 8'hA5, 8'(i * 7), 8'h3C};
  endfunction

  assign rf_rdata_a = rf[rf_raddr_a];
  assign rf_rdata_b = rf[rf_raddr_b];
  assign mem_ready  = mem_req && (wcnt >= wait_cycles);
  assign mem_rdata  = mem[mem_addr[9:2]];
  assign mem_err    = err_en && mem_addr == err_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= rf_pat(i);
      for (int i = 0; i < 256; i++) mem[i] <= 32'hD00D_0000 | (i * 17);
      wcnt <= 0;
    end else begin
      if (mem_req && mem_ready) begin
        wcnt <= 0;
        if (mem_we && !mem_err) mem[mem_addr[9:2]] <= mem_wdata;
        beat_log[nbeat % 8] <= mem_addr;
        nbeat <= nbeat + 1;
      end else if (mem_req) begin
        wcnt <= wcnt + 1;
      end
      if (rf_we0) rf[rf_waddr0] <= rf_wdata0;
      if (rf_we1) rf[rf_waddr1] <= rf_wdata1;
    end
  end

  // kind(2: 0 ld,1 sd,2 ldsp,3 sdsp) reg(5) base(3) off(9) illegal(1) wait(2)
  localparam int NV = 13;
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 5'd0,  3'd2, 9'd16,  1'b0, 2'd0},
    {2'd0, 5'd6,  3'd4, 9'd248, 1'b0, 2'd1},
    {2'd1, 5'd2,  3'd0, 9'd8,   1'b0, 2'd0},
    {2'd1, 5'd4,  3'd3, 9'd0,   1'b0, 2'd2},
    {2'd2, 5'd10, 3'd0, 9'd504, 1'b0, 2'd0},
    {2'd2, 5'd12, 3'd0, 9'd40,  1'b0, 2'd1},
    {2'd3, 5'd20, 3'd0, 9'd480, 1'b0, 2'd0},
    {2'd3, 5'd0,  3'd0, 9'd64,  1'b0, 2'd0},
    {2'd0, 5'd1,  3'd2, 9'd8,   1'b1, 2'd0},
    {2'd1, 5'd3,  3'd0, 9'd0,   1'b1, 2'd0},
    {2'd2, 5'd0,  3'd0, 9'd8,   1'b1, 2'd0},
    {2'd2, 5'd7,  3'd0, 9'd8,   1'b1, 2'd0},
    {2'd3, 5'd5,  3'd0, 9'd8,   1'b1, 2'd0}
  };

  function automatic logic [15:0] enc(logic [1:0] k, logic [4:0] r, logic [2:0] b, logic [8:0] o);
    case (k)
      2'd0:    return {3'b011, o[5:3], b, o[7:6], r[2:0], 2'b00};
      2'd1:    return {3'b111, o[5:3], b, o[7:6], r[2:0], 2'b00};
      2'd2:    return {3'b011, o[5], r, o[4:3], o[8:6], 2'b10};
      default: return {3'b111, o[5:3], o[8:6], r, 2'b10};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // res: 0 done, 1 illegal, 2 fault, 3 none
  task automatic run(input logic [15:0] w, output int res);
    @(negedge clk);
    insn = w;
    insn_valid = 1'b1;
    @(negedge clk);
    insn_valid = 1'b0;
    res = 3;
    for (int k = 0; k < 60; k++) begin
      if (done)    begin res = 0; break; end
      if (illegal) begin res = 1; break; end
      if (fault)   begin res = 2; break; end
      @(negedge clk);
    end
  endtask

  task automatic tests;
    int          res, nb0, breg, pr;
    logic [1:0]  kind;
    logic [4:0]  r;
    logic [2:0]  b;
    logic [8:0]  off;
    logic        ill;
    logic [31:0] a, a4, exp_lo, exp_hi, keep0, keep1;

    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 busy", {31'd0, busy}, 32'd0);
    chk("R11 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R11 pulses", {29'd0, done, illegal, fault}, 32'd0);
    chk("R11 writes", {30'd0, rf_we0, rf_we1}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {30'd0, busy, mem_req}, 32'd0);

    for (int v = 0; v < NV; v++) begin
      {kind, r, b, off, ill} = VEC[v][21:2];
      wait_cycles = int'(VEC[v][1:0]);
      breg = (kind < 2) ? 8 + int'(b) : 2;
      pr   = (kind < 2) ? 8 + int'(r[2:0]) : int'(r);
      a    = rf[breg] + {23'd0, off};
      a4   = a + 32'd4;
      if (kind == 2'd0 || kind == 2'd2) begin
        exp_lo = mem[a[9:2]];
        exp_hi = mem[a4[9:2]];
      end else begin
        exp_lo = (pr == 0) ? 32'd0 : rf[pr];
        exp_hi = (pr == 0) ? 32'd0 : rf[pr | 1];
      end
      nb0 = nbeat;
      run(enc(kind, r, b, off), res);
      if (ill) begin
        if (kind == 2'd2 && r == 5'd0) chk("R7 reserved x0 load", res, 1);
        else chk("R6 odd pair illegal", res, 1);
        repeat (2) @(negedge clk);
        chk("R6 no beat when illegal", nbeat - nb0, 0);
      end else begin
        chk("R1 decoded and done", res, 0);
        @(negedge clk);
        chk("R3 two beats", nbeat - nb0, 2);
        chk("R2 first beat address", beat_log[nb0 % 8], a);
        chk("R3 second beat address", beat_log[(nb0 + 1) % 8], a4);
        if (kind == 2'd0 || kind == 2'd2) begin
          chk("R4 low word to rd", rf[pr], exp_lo);
          chk("R4 high word to rd+1", rf[pr | 1], exp_hi);
        end else if (pr == 0) begin
          chk("R8 zero low word", mem[a[9:2]], 32'd0);
          chk("R8 zero high word", mem[a4[9:2]], 32'd0);
        end else begin
          chk("R5 rs2 at A", mem[a[9:2]], exp_lo);
          chk("R5 rs2+1 at A+4", mem[a4[9:2]], exp_hi);
        end
      end
    end
    wait_cycles = 0;

    // R1 other encodings
    run(16'h0001, res);
    chk("R1 quadrant 01 illegal", res, 1);
    run(16'h4000, res);
    chk("R1 funct3 010 illegal", res, 1);

    // R10 busy and no acceptance while busy
    wait_cycles = 3;
    nb0 = nbeat;
    @(negedge clk);
    insn = enc(2'd0, 5'd2, 3'd1, 9'd24);
    insn_valid = 1'b1;
    @(negedge clk);
    insn = enc(2'd1, 5'd4, 3'd1, 9'd32);
    res = 1;
    for (int k = 0; k < 40; k++) begin
      if (done) break;
      if (!busy) res = 0;
      @(negedge clk);
    end
    chk("R10 busy until done", {31'd0, busy && done}, 32'd1);
    chk("R10 busy held", res, 1);
    insn_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 second instruction not taken", nbeat - nb0, 2);
    chk("R10 idle afterwards", {31'd0, busy}, 32'd0);
    wait_cycles = 0;

    // R9 load fault on second beat leaves pair unchanged
    a = rf[9 + 1 - 1 + 1] + 32'd16;
    keep0 = rf[12];
    keep1 = rf[13];
    err_addr = a + 32'd4;
    err_en = 1'b1;
    nb0 = nbeat;
    run(enc(2'd0, 5'd4, 3'd2, 9'd16), res);
    chk("R9 fault on load", res, 2);
    repeat (2) @(negedge clk);
    chk("R9 rd unchanged", rf[12], keep0);
    chk("R9 rd+1 unchanged", rf[13], keep1);
    chk("R9 no beat after fault", nbeat - nb0, 2);

    // R9 store fault on first beat
    a = rf[2] + 32'd128;
    keep0 = mem[a[9:2]];
    a4 = a + 32'd4;
    keep1 = mem[a4[9:2]];
    err_addr = a;
    nb0 = nbeat;
    run(enc(2'd3, 5'd14, 3'd0, 9'd128), res);
    err_en = 1'b0;
    chk("R9 fault on store", res, 2);
    repeat (2) @(negedge clk);
    chk("R9 single beat", nbeat - nb0, 1);
    chk("R9 memory A unchanged", mem[a[9:2]], keep0);
    chk("R9 memory A+4 unchanged", mem[a4[9:2]], keep1);
  endtask

  initial begin
    fork
      tests();
      begin
        repeat (20000) @(negedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule